// File: doc/BRIEF.md
# Monitored-Clock Presence and Frequency Window Supervisor

This block watches a fast, internally generated clock and the lock indication that comes with it. It judges both against a stable reference clock. It reports three conditions on separate status bits:

- **Lock lost**: the lock indication has dropped, or the clock has stopped.
- **Too slow**: the measured frequency is under a lower limit (45 MHz by default).
- **Too fast**: the measured frequency is over an upper limit (140 MHz by default).

Whenever any of the three is set, the block asks for the power output stages to be placed in high impedance. Each bit clears by itself once its condition has gone away, and operation then resumes.

The measurement works as follows. In the monitored domain, the clock is divided by a small prescaler and drives a Gray-coded progress counter. The reference domain resynchronizes that counter. It takes a sample once per fixed window of reference cycles. The difference between two consecutive samples is compared with limits derived from the window length, the prescaler and the two MHz thresholds. A window with no progress at all is treated as a stopped clock. None of these conditions drives the external diagnostic pin; they are visible only as status bits.

Top module: `clkmon_top`

## Requirements
- R1: While rst_n is low, st_under and st_over read 0, st_lock_lost reads 1 and hiz_req reads 1.
- R2: A low level on pll_lock sets st_lock_lost after exactly two reference edges (not after one). A high level clears it after the same two-edge delay, provided the clock is running.
- R3: A whole measurement window with no monitored-clock progress sets st_lock_lost at that window's end and clears st_under and st_over. The first window end with progress clears it again.
- R4: st_under is 1 after a window whose measured count is nonzero but below the 45 MHz limit. It is 0 after a window at or above that limit.
- R5: st_over is 1 after a window whose measured count exceeds the 140 MHz limit. It is 0 after a window at or below that limit.
- R6: st_under and st_over, and the stopped-clock part of st_lock_lost, change only at a window end. A window end occurs every WIN reference cycles; the first one is at the WIN-th edge after reset release.
- R7: hiz_req is 1 exactly when at least one of st_lock_lost, st_under and st_over is 1.
- R8: The first window after reset only takes a baseline. st_under, st_over and the stopped-clock part of st_lock_lost stay 0 until the second window end.
- R9: st_under and st_over are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (REF_MHZ) |
| rst_n | input | 1 | Synchronous active-low reset, reference domain |
| mon_clk | input | 1 | Monitored high-speed clock |
| pll_lock | input | 1 | Lock indication of the monitored clock, asynchronous |
| st_lock_lost | output | 1 | Lock dropped or monitored clock stopped |
| st_under | output | 1 | Monitored frequency below lower limit |
| st_over | output | 1 | Monitored frequency above upper limit |
| hiz_req | output | 1 | Request to place output stages in high impedance |

## Verification
The assertions assume the following about the inputs:

- The monitored clock stays below PRE times the reference frequency, so the Gray counter moves at most one step per reference cycle and every resynchronized sample is a valid code.
- pll_lock is a plain level that the synchronizer can sample.

The stimulus keeps to these limits. It uses monitored periods between 6 ns and 25 ns, with the prescaler at four. It also changes the frequency, the lock level and the run/stop state only in the middle of a window. As a result, the second window end after any change always measures the new condition cleanly.

// File: rtl/clkmon_pkg.sv
// Shared types for the clock supervisor.
package clkmon_pkg;

    // Fault status of the monitored clock.
    typedef struct packed {
        logic lost;
        logic under;
        logic over;
    } clkmon_flags_t;

    // True when any fault requires the outputs to float.
    function automatic logic any_fault(input clkmon_flags_t f);
        return f.lost | f.under | f.over;
    endfunction

endpackage

// File: rtl/clkmon_sync.sv
// Multi-stage flop synchronizer.
// Assumes: for W > 1 the input changes at most one bit per destination edge (Gray code).
module clkmon_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage toward the output; synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkmon_gray_cnt.sv
// Monitored-domain progress counter: divides mon_clk by PRE and counts the
// divided events in Gray code so the reference domain can sample it safely.
// Assumes: PRE >= 2; the reset arrives from the reference domain and is
// resynchronized here (it takes effect only while mon_clk runs).
module clkmon_gray_cnt #(
    parameter int PRE = 4,
    parameter int CW  = 11
) (
    input  logic          mon_clk,
    input  logic          rst_n,
    output logic [CW-1:0] gray
);
    localparam int PW = (PRE > 2) ? $clog2(PRE) : 1;

    logic          mrst_n;
    logic [PW-1:0] pre_cnt;
    logic [CW-1:0] bin;
    logic [CW-1:0] bin_nxt;

    clkmon_sync #(.W(1), .STAGES(2)) u_rsync (
        .clk  (mon_clk),
        .rst_n(1'b1),
        .d    (rst_n),
        .q    (mrst_n)
    );

    assign bin_nxt = bin + 1'b1;

    // Prescale mon_clk and advance the binary and Gray counters together.
    always_ff @(posedge mon_clk) begin
        if (!mrst_n) begin
            pre_cnt <= '0;
            bin     <= '0;
            gray    <= '0;
        end else if (pre_cnt == PW'(PRE-1)) begin
            pre_cnt <= '0;
            bin     <= bin_nxt;
            gray    <= bin_nxt ^ (bin_nxt >> 1);
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkmon_window.sv
// Reference-domain window timer and classifier. Every WIN cycles it decodes
// the synchronized Gray count, takes the progress since the previous window
// end, and classifies it as stopped, too slow or too fast.
// Assumes: gray_s is a valid Gray code in every cycle; progress per window < 2**CW.
module clkmon_window #(
    parameter int WIN    = 1024,
    parameter int CW     = 11,
    parameter int LO_CNT = 115,
    parameter int HI_CNT = 358
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_s,
    output logic          tick,
    output logic          stopped,
    output logic          under,
    output logic          over
);
    localparam int          TW   = $clog2(WIN);
    localparam logic [CW-1:0] LO_C = CW'(LO_CNT);
    localparam logic [CW-1:0] HI_C = CW'(HI_CNT);

    logic [TW-1:0] win_cnt;
    logic [CW-1:0] cur_bin;
    logic [CW-1:0] prev_bin;
    logic [CW-1:0] delta;
    logic          primed;

    // Gray-to-binary decode of the sampled count.
    always_comb begin
        for (int i = 0; i < CW; i++) cur_bin[i] = ^(gray_s >> i);
    end

    assign tick  = (win_cnt == TW'(WIN-1));
    assign delta = cur_bin - prev_bin;

    // Window timing, baseline capture and flag update at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            prev_bin <= '0;
            primed   <= 1'b0;
            stopped  <= 1'b0;
            under    <= 1'b0;
            over     <= 1'b0;
        end else if (tick) begin
            win_cnt  <= '0;
            prev_bin <= cur_bin;
            primed   <= 1'b1;
            if (primed) begin
                stopped <= (delta == '0);
                under   <= (delta != '0) && (delta < LO_C);
                over    <= (delta > HI_C);
            end
        end else begin
            win_cnt <= win_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkmon_top.sv
// Clock supervisor top: lock synchronizer, monitored-domain progress counter,
// count resynchronizer and window classifier; merges the faults into the
// high-impedance request.
// Assumes: mon_clk frequency < PRE * REF_MHZ; thresholds are integer MHz.
module clkmon_top
    import clkmon_pkg::*;
#(
    parameter int REF_MHZ = 100,
    parameter int LO_MHZ  = 45,
    parameter int HI_MHZ  = 140,
    parameter int WIN     = 1024,
    parameter int PRE     = 4,
    parameter int SYNC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    input  logic pll_lock,
    output logic st_lock_lost,
    output logic st_under,
    output logic st_over,
    output logic hiz_req
);
    localparam int CW     = $clog2(WIN) + 1;
    localparam int LO_CNT = (LO_MHZ * WIN) / (REF_MHZ * PRE);
    localparam int HI_CNT = (HI_MHZ * WIN) / (REF_MHZ * PRE);

    logic          lock_s;
    logic [CW-1:0] gray_m;
    logic [CW-1:0] gray_s;
    logic          win_tick;
    logic          stopped;
    clkmon_flags_t flags;

    clkmon_sync #(.W(1), .STAGES(SYNC)) u_lsync (
        .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
    );

    clkmon_gray_cnt #(.PRE(PRE), .CW(CW)) u_cnt (
        .mon_clk(mon_clk), .rst_n(rst_n), .gray(gray_m)
    );

    clkmon_sync #(.W(CW), .STAGES(SYNC)) u_csync (
        .clk(clk), .rst_n(rst_n), .d(gray_m), .q(gray_s)
    );

    clkmon_window #(.WIN(WIN), .CW(CW), .LO_CNT(LO_CNT), .HI_CNT(HI_CNT)) u_win (
        .clk(clk), .rst_n(rst_n), .gray_s(gray_s), .tick(win_tick),
        .stopped(stopped), .under(st_under), .over(st_over)
    );

    // Gather fault status for the merge.
    always_comb begin
        flags.lost  = !lock_s || stopped;
        flags.under = st_under;
        flags.over  = st_over;
    end

    assign st_lock_lost = flags.lost;
    assign hiz_req      = any_fault(flags);
endmodule

// File: rtl/clkmon_chk.sv
// Assertion checker for clkmon_top, attached by bind.
module clkmon_chk (
    input logic clk,
    input logic rst_n,
    input logic pll_lock,
    input logic win_tick,
    input logic st_lock_lost,
    input logic st_under,
    input logic st_over
);
    // R9
    under_over_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_under && st_over));

    // R2
    lock_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pll_lock, 2) |-> st_lock_lost);

    // R6
    under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> $stable(st_under));

    // R6
    over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_tick |=> $stable(st_over));

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_tick |=> !win_tick);
endmodule

bind clkmon_top clkmon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .win_tick(win_tick),
    .st_lock_lost(st_lock_lost), .st_under(st_under), .st_over(st_over)
);

// File: tb/sim_clkmon_top.sv
`timescale 1ns/1ps
module sim_clkmon_top;
    localparam int WIN = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic pll_lock = 1'b1;
    logic st_lock_lost, st_under, st_over, hiz_req;

    realtime mon_half = 12.5;
    bit      mon_run  = 1'b1;
    int      checks = 0, failures = 0;
    int      cyc = 0;
    int      settle_at = 2*WIN + 2;
    int      lock_settle_at = 0;
    bit      done = 1'b0;
    int      lock_hist[$];

    clkmon_top u0 (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .pll_lock(pll_lock),
        .st_lock_lost(st_lock_lost), .st_under(st_under), .st_over(st_over),
        .hiz_req(hiz_req)
    );

    always #5 clk = ~clk;

    always begin
        if (mon_run) #(mon_half) mon_clk = ~mon_clk;
        else #1;
    end

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        lock_hist.push_back(int'(pll_lock));
        if (lock_hist.size() > 4) void'(lock_hist.pop_front());
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b cyc=%0d", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference: classify the current stimulus.
    function automatic real mon_mhz();
        return 1000.0 / (2.0 * mon_half);
    endfunction

    // Per-clock comparison once the stimulus has settled.
    always @(negedge clk) begin
        if (rst_n && !done && cyc >= settle_at && cyc >= lock_settle_at) begin
            logic e_stop, e_under, e_over, e_lost;
            e_stop  = !mon_run;
            e_under = mon_run && (mon_mhz() < 45.0);
            e_over  = mon_run && (mon_mhz() > 140.0);
            e_lost  = (lock_hist.size() < 3) ? 1'b1 : (lock_hist[lock_hist.size()-3] == 0) || e_stop;
            chk("R4", "model st_under", st_under, e_under);
            chk("R5", "model st_over", st_over, e_over);
            chk("R3", "model st_lock_lost", st_lock_lost, e_lost);
            chk("R7", "model hiz_req", hiz_req, e_under | e_over | e_lost);
            chk("R9", "model excl", st_under & st_over, 1'b0);
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic goto_mid();
        @(negedge clk);
        while ((cyc % WIN) != WIN/2) @(negedge clk);
        #1;
    endtask

    task automatic set_mon(input bit run, input realtime half);
        goto_mid();
        mon_run   = run;
        mon_half  = half;
        settle_at = (cyc / WIN + 2) * WIN + 2;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired cyc=%0d", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int m;
        repeat (20) @(negedge clk);
        chk("R1", "reset st_under", st_under, 1'b0);
        chk("R1", "reset st_over", st_over, 1'b0);
        chk("R1", "reset st_lock_lost", st_lock_lost, 1'b1);
        chk("R1", "reset hiz_req", hiz_req, 1'b1);
        #1 rst_n = 1'b1;

        // R8: 40 MHz from reset, first window only establishes a baseline
        wait_cyc(WIN + WIN/2);
        chk("R8", "baseline st_under", st_under, 1'b0);
        chk("R8", "baseline st_lock_lost", st_lock_lost, 1'b0);
        wait_cyc(2*WIN + WIN/2);
        chk("R4", "40MHz st_under", st_under, 1'b1);
        chk("R7", "40MHz hiz_req", hiz_req, 1'b1);

        // 100 MHz: all clear
        set_mon(1'b1, 5.0);
        m = cyc;
        wait_cyc((m / WIN + 1) * WIN - 1);
        chk("R6", "held until window end", st_under, 1'b1);
        wait_cyc(settle_at + WIN/4);
        chk("R4", "100MHz st_under", st_under, 1'b0);
        chk("R7", "100MHz hiz_req", hiz_req, 1'b0);

        // 166.7 MHz: too fast
        set_mon(1'b1, 3.0);
        wait_cyc(settle_at + WIN/4);
        chk("R5", "166MHz st_over", st_over, 1'b1);
        chk("R9", "166MHz st_under", st_under, 1'b0);

        // 125 MHz: too fast clears
        set_mon(1'b1, 4.0);
        wait_cyc(settle_at + WIN/4);
        chk("R5", "125MHz st_over", st_over, 1'b0);

        // R2: lock drop latency
        goto_mid();
        lock_settle_at = cyc + 1000000;
        pll_lock = 1'b0;
        @(negedge clk);
        chk("R2", "lock drop after 1 edge", st_lock_lost, 1'b0);
        @(negedge clk);
        chk("R2", "lock drop after 2 edges", st_lock_lost, 1'b1);
        chk("R7", "lock drop hiz_req", hiz_req, 1'b1);
        #1 pll_lock = 1'b1;
        @(negedge clk);
        chk("R2", "lock return after 1 edge", st_lock_lost, 1'b1);
        @(negedge clk);
        chk("R2", "lock return after 2 edges", st_lock_lost, 1'b0);
        lock_settle_at = cyc + 3;

        // R3: stopped clock
        set_mon(1'b0, 4.0);
        wait_cyc(settle_at + WIN/4);
        chk("R3", "stopped st_lock_lost", st_lock_lost, 1'b1);
        chk("R3", "stopped st_under", st_under, 1'b0);
        set_mon(1'b1, 10.0);
        wait_cyc(settle_at + WIN/4);
        chk("R3", "restart 50MHz st_lock_lost", st_lock_lost, 1'b0);
        chk("R4", "50MHz st_under", st_under, 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule